// File: doc/BRIEF.md
# Nested Loop End-Point Flag Generator

This block walks a schedule of up to three nested loops and produces one output element per loop iteration. Each element carries its linear position in the schedule and a 4-bit condition field. The field shows which loop counters sit at their last value on that element, plus a separate marker that appears only on the final element. A consumer can branch on these markers to close inner, middle or outer loops without recomputing the loop bounds.

The three dimension sizes are given as size-minus-one values, so each dimension covers 1 to 32 iterations. A start pulse while the block is idle captures the sizes and begins the walk. Elements leave through a valid/ready handshake, and the walk advances only when an element is accepted. The innermost dimension runs fastest. After the last element is accepted, the block goes idle and raises done until the next start. The element count is the product of the three sizes; a 5 by 7 by 3 schedule yields 105 elements.

Top module: `loop_end_walker`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` and `done` are 0.
- R2: A `start` pulse seen at a clock edge while `out_valid` is 0 makes `out_valid` 1 from the next cycle, with `out_index` 0. The sizes are captured at that edge, and later changes to the size inputs do not affect the walk.
- R3: Each accepted element (`out_valid` and `out_ready` both 1 at an edge) is followed by the next one, whose `out_index` is one higher. A walk emits exactly (size_inner_m1+1)*(size_mid_m1+1)*(size_outer_m1+1) elements, numbered 0 upward.
- R4: The inner counter advances on every accepted element and the middle counter advances when the inner one wraps. The outer counter advances when both the inner and the middle counters wrap. Bit 1 of `out_flags` (EQ) is 1 exactly when the inner counter is at its last value.
- R5: Bit 3 of `out_flags` (LT) is 1 exactly when the middle counter is at its last value.
- R6: Bit 2 of `out_flags` (GT) is 1 exactly when the outer counter is at its last value.
- R7: Bit 0 of `out_flags` (SO) is 1 only on the final element of the walk, where all three counters are at their last values.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_index` and `out_flags` hold their values.
- R9: On the cycle after the final element is accepted, `out_valid` is 0 and `done` is 1. `done` stays 1 until the next accepted start, and it is 0 during a walk.
- R10: A `start` pulse while a walk is in progress is ignored. The sequence of elements continues unchanged.
- R11: A dimension with size-minus-one 0 has its end marker set on every element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a walk when idle |
| size_inner_m1 | input | 5 | Innermost dimension size minus one |
| size_mid_m1 | input | 5 | Middle dimension size minus one |
| size_outer_m1 | input | 5 | Outermost dimension size minus one |
| out_ready | input | 1 | Consumer accepts the current element |
| out_valid | output | 1 | Current element is valid |
| out_index | output | 15 | Linear index of the element |
| out_flags | output | 4 | {LT mid end, GT outer end, EQ inner end, SO last} |
| done | output | 1 | Walk finished, held until next start |

## Verification
Every result is one register stage from its cause. The first element appears on the cycle after the start edge. Each following element appears on the cycle after an accepting edge, and done rises on the cycle after the final acceptance. The bench drives inputs and samples outputs only on falling edges, so each sample falls one full edge after the stimulus that caused it. A stalled cycle is compared against the same expected element as the cycle before it. The bench sweeps all 27 size combinations with each dimension size-minus-one in 0..2, plus a 5x7x3 schedule and a 32x1x1 schedule. It uses a repeating ready pattern that stalls one cycle in three.

// File: rtl/loop_end_walker.sv
module loop_end_walker #(
  parameter int CNT_W = 5,
  localparam int IDX_W = 3 * CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] size_inner_m1,
  input  logic [CNT_W-1:0] size_mid_m1,
  input  logic [CNT_W-1:0] size_outer_m1,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_index,
  output logic [3:0]       out_flags,
  output logic             done
);

  logic             busy, fin;
  logic [CNT_W-1:0] ci, cm, co;
  logic [CNT_W-1:0] li, lm, lo;
  logic [IDX_W-1:0] idx;

  wire end_i = (ci == li);
  wire end_m = (cm == lm);
  wire end_o = (co == lo);
  wire last  = end_i & end_m & end_o;
  wire take  = busy & out_ready;

  assign out_valid = busy;
  assign out_index = idx;
  assign out_flags = {end_m, end_o, end_i, last};
  assign done      = fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      fin  <= 1'b0;
      ci   <= '0;
      cm   <= '0;
      co   <= '0;
      li   <= '0;
      lm   <= '0;
      lo   <= '0;
      idx  <= '0;
    end else if (!busy && start) begin
      busy <= 1'b1;
      fin  <= 1'b0;
      li   <= size_inner_m1;
      lm   <= size_mid_m1;
      lo   <= size_outer_m1;
      ci   <= '0;
      cm   <= '0;
      co   <= '0;
      idx  <= '0;
    end else if (take) begin
      if (last) begin
        busy <= 1'b0;
        fin  <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
        if (end_i) begin
          ci <= '0;
          if (end_m) begin
            cm <= '0;
            co <= co + 1'b1;
          end else begin
            cm <= cm + 1'b1;
          end
        end else begin
          ci <= ci + 1'b1;
        end
      end
    end
  end

  AST_FIRST_ELEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && start) |=> (out_valid && out_index == '0)); // R2

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_flags[0]) |=> (out_valid && out_index == $past(out_index) + 1'b1)); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_index) && $stable(out_flags))); // R8

  AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_flags[0]) |=> (!out_valid && done)); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid); // R9

endmodule

// File: tb/test_loop_end_walker.sv
module test_loop_end_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  size_inner_m1 = '0, size_mid_m1 = '0, size_outer_m1 = '0;
  logic        out_ready = 1'b0;
  logic        out_valid, done;
  logic [14:0] out_index;
  logic [3:0]  out_flags;

  int checks = 0;
  int errors = 0;
  int tick = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  loop_end_walker i_loop_end_walker (
    .clk(clk), .rst_n(rst_n), .start(start),
    .size_inner_m1(size_inner_m1), .size_mid_m1(size_mid_m1), .size_outer_m1(size_outer_m1),
    .out_ready(out_ready), .out_valid(out_valid), .out_index(out_index),
    .out_flags(out_flags), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int li, input int lm, input int lo, input bit poke);
    int total, n, ci, cm, co;
    bit rdy;
    @(negedge clk);
    size_inner_m1 = li[4:0];
    size_mid_m1   = lm[4:0];
    size_outer_m1 = lo[4:0];
    start = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    size_inner_m1 = ~li[4:0];
    size_mid_m1   = 5'd31 - lm[4:0];
    size_outer_m1 = lo[4:0] ^ 5'd9;
    total = (li + 1) * (lm + 1) * (lo + 1);
    n = 0; ci = 0; cm = 0; co = 0;
    while (n < total) begin
      chk(out_valid == 1'b1, (n == 0) ? "R2 valid" : "R8 valid", int'(out_valid), 1);
      chk(done == 1'b0, "R9 done low in walk", int'(done), 0);
      chk(out_index == n[14:0], (n == 0) ? "R2 index" : "R3 index", int'(out_index), n);
      chk(out_flags[1] == (ci == li), "R4 EQ", int'(out_flags[1]), int'(ci == li));
      chk(out_flags[3] == (cm == lm), "R5 LT", int'(out_flags[3]), int'(cm == lm));
      chk(out_flags[2] == (co == lo), "R6 GT", int'(out_flags[2]), int'(co == lo));
      chk(out_flags[0] == (n == total - 1), "R7 SO", int'(out_flags[0]), int'(n == total - 1));
      if (li == 0) chk(out_flags[1] == 1'b1, "R11 inner size one", int'(out_flags[1]), 1);
      if (lm == 0) chk(out_flags[3] == 1'b1, "R11 mid size one", int'(out_flags[3]), 1);
      if (lo == 0) chk(out_flags[2] == 1'b1, "R11 outer size one", int'(out_flags[2]), 1);
      rdy = (tick % 3) != 1;
      tick++;
      if (poke && n == 2 && n != total - 1) start = 1'b1;
      out_ready = rdy;
      @(negedge clk);
      start = 1'b0;
      if (rdy) begin
        n++;
        if (ci == li) begin
          ci = 0;
          if (cm == lm) begin cm = 0; co++; end
          else cm++;
        end else ci++;
      end
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0, poke ? "R10 walk length" : "R9 valid low", int'(out_valid), 0);
    chk(done == 1'b1, "R9 done", int'(done), 1);
    @(negedge clk);
    @(negedge clk);
    chk(done == 1'b1, "R9 done held", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          run(a, b, c, 1'b0);
    run(4, 6, 2, 1'b1);
    run(31, 0, 0, 1'b1);
    run(1, 2, 1, 1'b1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule